// File: doc/BRIEF.md
# Flag-Conditioned Set-and-Branch Unit

This unit carries out the combined "set register and branch" operation of a small 32-bit processor. Each accepted operation brings a 4-bit condition code, the flags word, a destination register index, the current program counter and a 16-bit branch displacement. The unit tests up to three flag bits against a common polarity. From that result it builds a register write carrying 1 or 0, and it builds the address of the next instruction.

The flag test is a masked compare. The low three condition bits choose which flags take part. The top condition bit gives the value that every chosen flag must have. The highest flag bit is always treated as set, so one mask value turns the operation into an unconditional branch or a never-taken one, depending on the polarity. A zero displacement gives a pure conditional set. A destination index that names a hardwired register gives a pure branch, because the write is dropped.

The evaluation is combinational and feeds a single registered output slot. The input side and the output side each follow a valid/ready handshake.

Top module: `flag_branch_unit`

## Requirements
- R1: The condition holds when every flag chosen by cond[2:0] equals cond[3]. cond[2] chooses flags[31], cond[1] chooses flags[30] and cond[0] chooses flags[29].
- R2: When cond[2:0] is 000, the condition always holds, whatever the value of cond[3].
- R3: flags[31] is treated as 1 even when the input bit is 0. So cond 4'b1100 is always taken, and cond 4'b0100 is never taken.
- R4: The write data is 32'd1 when the condition holds and 32'd0 otherwise. The write index equals the destination index that was accepted.
- R5: When the condition holds, the next PC is PC + 4 plus the sign-extended 16-bit displacement, in modulo 2^32 arithmetic.
- R6: When the condition does not hold, the next PC is PC + 4.
- R7: The write enable is 0 for destination indices 0 and 1, which are hardwired. It is 1 for every other index.
- R8: in_ready equals (!out_valid || out_ready). While out_valid is 1 and out_ready is 0, all outputs hold their values.
- R9: While reset is asserted, out_valid is 0.
- R10: An operation accepted on one clock edge appears on the outputs, with out_valid set, directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can accept an operation |
| in_cond | input | 4 | Condition code: polarity in bit 3, flag mask in bits 2:0 |
| in_flags | input | 32 | Flags word; bits 31:29 are tested |
| in_dst | input | 4 | Destination register index |
| in_pc | input | 32 | Address of the set-and-branch operation |
| in_offset | input | 16 | Signed branch displacement |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer takes the result |
| out_wr_en | output | 1 | Register write enable |
| out_wr_idx | output | 4 | Register write index |
| out_wr_data | output | 32 | Register write data, 0 or 1 |
| out_next_pc | output | 32 | Address of the next instruction |
| out_taken | output | 1 | The condition held |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 16-bit sign-extended displacement, an instruction length of 4 bytes, a target relative to the next instruction, and two hardwired registers. With these values the bench can reach every condition code against every combination of the three tested flags, including an input word whose bit 31 is cleared. It can also reach displacements of 0x7FFF, 0x8000 and 0xFFFF, a program counter that wraps past 2^32, and the suppressed write to indices 0 and 1. Output back-pressure is applied in a periodic pattern and in one long stall, so the hold behaviour of the output slot is exercised.

// File: rtl/sb_pkg.sv
package sb_pkg;

   // Width of the condition code as carried in the instruction word
   localparam int COND_W = 4;
   // Number of flags that a condition can test
   localparam int NFLAGS = 3;

   typedef logic [COND_W-1:0] sb_cond_t;
   typedef logic [NFLAGS-1:0] sb_flags_t;

   // Polarity bit and mask bits of a condition code
   function automatic logic sb_polarity(input sb_cond_t c);
      return c[COND_W-1];
   endfunction

   function automatic sb_flags_t sb_mask(input sb_cond_t c);
      return c[NFLAGS-1:0];
   endfunction

endpackage

// File: rtl/sb_cond_eval.sv
module sb_cond_eval
   import sb_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int FLAG_LSB  = 29,
   parameter bit FORCE_TOP = 1'b1
) (
   input  sb_cond_t          cond,
   input  logic [XLEN-1:0]   flags,
   output logic              hit
);
   localparam int FLAG_MSB = FLAG_LSB + NFLAGS - 1;

   if (FLAG_MSB >= XLEN) begin : g_bad_flag_pos
      $error("sb_cond_eval: flag field lies outside the flags word");
   end

   sb_flags_t fsel;

   if (FORCE_TOP) begin : g_force_top
      assign fsel = {1'b1, flags[FLAG_MSB-1:FLAG_LSB]};
   end else begin : g_pass_top
      assign fsel = flags[FLAG_MSB:FLAG_LSB];
   end

   wire unused_flags = ^flags;

   sb_flags_t mask;
   sb_flags_t want;

   always_comb begin
      mask = sb_mask(cond);
      want = {NFLAGS{sb_polarity(cond)}} & mask;
      hit  = ((fsel & mask) == want);
   end
endmodule

// File: rtl/sb_target_calc.sv
module sb_target_calc #(
   parameter int XLEN        = 32,
   parameter int OFS_W       = 16,
   parameter int ILEN_BYTES  = 4,
   parameter bit SEXT_OFFSET = 1'b1,
   parameter bit REL_TO_NEXT = 1'b1
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [OFS_W-1:0] offset,
   input  logic             taken,
   output logic [XLEN-1:0]  next_pc
);
   localparam int EXT_W = XLEN - OFS_W;

   if (OFS_W >= XLEN) begin : g_bad_ofs
      $error("sb_target_calc: displacement must be narrower than the datapath");
   end

   logic [XLEN-1:0] disp;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] base;

   if (SEXT_OFFSET) begin : g_sext
      assign disp = {{EXT_W{offset[OFS_W-1]}}, offset};
   end else begin : g_zext
      assign disp = {{EXT_W{1'b0}}, offset};
   end

   assign seq_pc = pc + XLEN'(ILEN_BYTES);

   if (REL_TO_NEXT) begin : g_rel_next
      assign base = seq_pc;
   end else begin : g_rel_self
      assign base = pc;
   end

   assign next_pc = taken ? (base + disp) : seq_pc;
endmodule

// File: rtl/sb_wr_gate.sv
module sb_wr_gate #(
   parameter int IDX_W     = 4,
   parameter int NUM_FIXED = 2
) (
   input  logic [IDX_W-1:0] dst,
   output logic             wr_en
);
   if (NUM_FIXED < 0 || NUM_FIXED > (1 << IDX_W)) begin : g_bad_fixed
      $error("sb_wr_gate: hardwired register count out of range");
   end

   if (NUM_FIXED == 0) begin : g_no_fixed
      assign wr_en = 1'b1;
   end else begin : g_fixed
      assign wr_en = ({1'b0, dst} >= (IDX_W+1)'(NUM_FIXED));
   end
endmodule

// File: rtl/sb_out_stage.sv
module sb_out_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   if (W < 1) begin : g_bad_w
      $error("sb_out_stage: payload width must be positive");
   end

   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
   import sb_pkg::*;
#(
   parameter int XLEN        = 32,
   parameter int OFS_W       = 16,
   parameter int IDX_W       = 4,
   parameter int ILEN_BYTES  = 4,
   parameter int FLAG_LSB    = 29,
   parameter int NUM_FIXED   = 2,
   parameter bit SEXT_OFFSET = 1'b1,
   parameter bit REL_TO_NEXT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [3:0]       in_cond,
   input  logic [XLEN-1:0]  in_flags,
   input  logic [IDX_W-1:0] in_dst,
   input  logic [XLEN-1:0]  in_pc,
   input  logic [OFS_W-1:0] in_offset,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             out_wr_en,
   output logic [IDX_W-1:0] out_wr_idx,
   output logic [XLEN-1:0]  out_wr_data,
   output logic [XLEN-1:0]  out_next_pc,
   output logic             out_taken
);
   localparam int PAY_W = 2 + IDX_W + XLEN;

   if (ILEN_BYTES < 1) begin : g_bad_ilen
      $error("flag_branch_unit: instruction length must be positive");
   end

   logic            hit;
   logic            wen;
   logic [XLEN-1:0] npc;
   logic [PAY_W-1:0] pay_in;
   logic [PAY_W-1:0] pay_out;

   sb_cond_eval #(
      .XLEN(XLEN), .FLAG_LSB(FLAG_LSB), .FORCE_TOP(1'b1)
   ) u_cond (
      .cond(in_cond), .flags(in_flags), .hit(hit)
   );

   sb_target_calc #(
      .XLEN(XLEN), .OFS_W(OFS_W), .ILEN_BYTES(ILEN_BYTES),
      .SEXT_OFFSET(SEXT_OFFSET), .REL_TO_NEXT(REL_TO_NEXT)
   ) u_target (
      .pc(in_pc), .offset(in_offset), .taken(hit), .next_pc(npc)
   );

   sb_wr_gate #(
      .IDX_W(IDX_W), .NUM_FIXED(NUM_FIXED)
   ) u_gate (
      .dst(in_dst), .wr_en(wen)
   );

   assign pay_in = {hit, wen, in_dst, npc};

   sb_out_stage #(.W(PAY_W)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(pay_in),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_out)
   );

   assign out_taken   = pay_out[PAY_W-1];
   assign out_wr_en   = pay_out[PAY_W-2];
   assign out_wr_idx  = pay_out[XLEN +: IDX_W];
   assign out_next_pc = pay_out[XLEN-1:0];
   assign out_wr_data = {{(XLEN-1){1'b0}}, out_taken};
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
   parameter int XLEN       = 32,
   parameter int IDX_W      = 4,
   parameter int ILEN_BYTES = 4,
   parameter int NUM_FIXED  = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic [3:0]       in_cond,
   input logic [XLEN-1:0]  in_pc,
   input logic             out_valid,
   input logic             out_ready,
   input logic             out_wr_en,
   input logic [IDX_W-1:0] out_wr_idx,
   input logic [XLEN-1:0]  out_wr_data,
   input logic [XLEN-1:0]  out_next_pc,
   input logic             out_taken
);
   logic accept;
   assign accept = in_valid && in_ready;

   // R10: an accepted operation is presented directly after the edge
   a_r10_present: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid);

   // R8: a stalled result stays put
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_next_pc)
         && $stable(out_taken) && $stable(out_wr_idx) && $stable(out_wr_en)));

   // R3: polarity 1 with the top flag selected alone is always taken
   a_r3_always: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_cond == 4'b1100) |=> out_taken);

   // R3: polarity 0 with the top flag selected alone is never taken
   a_r3_never: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_cond == 4'b0100) |=> !out_taken);

   // R6: a fall-through goes to the sequential address
   a_r6_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (out_taken || out_next_pc == $past(in_pc) + XLEN'(ILEN_BYTES)));

   // R7: hardwired registers are never written
   a_r7_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && ({1'b0, out_wr_idx} < (IDX_W+1)'(NUM_FIXED))) |-> !out_wr_en);

   // R4: write data is 0 or 1 and matches the decision
   a_r4_data: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(out_wr_data) == int'(out_taken) && out_wr_data[0] == out_taken));
endmodule

bind flag_branch_unit sb_checker #(
   .XLEN(XLEN), .IDX_W(IDX_W), .ILEN_BYTES(ILEN_BYTES), .NUM_FIXED(NUM_FIXED)
) u_sb_checker (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_cond(in_cond), .in_pc(in_pc), .out_valid(out_valid), .out_ready(out_ready),
   .out_wr_en(out_wr_en), .out_wr_idx(out_wr_idx), .out_wr_data(out_wr_data),
   .out_next_pc(out_next_pc), .out_taken(out_taken)
);

// File: tb/test_flag_branch_unit.sv
module test_flag_branch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  in_cond = '0;
   logic [31:0] in_flags = '0;
   logic [3:0]  in_dst = '0;
   logic [31:0] in_pc = '0;
   logic [15:0] in_offset = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic        out_wr_en;
   logic [3:0]  out_wr_idx;
   logic [31:0] out_wr_data;
   logic [31:0] out_next_pc;
   logic        out_taken;

   int n_checks = 0;
   int n_fails  = 0;
   bit hold = 1'b0;
   bit acc_last = 1'b0;

   // reference state
   bit          m_v = 1'b0;
   bit          m_taken;
   bit          m_wen;
   logic [3:0]  m_idx;
   logic [31:0] m_pc;
   logic [3:0]  m_cond;

   always #4 clk = ~clk;   // 125 MHz

   flag_branch_unit i_flag_branch_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_cond(in_cond), .in_flags(in_flags), .in_dst(in_dst), .in_pc(in_pc),
      .in_offset(in_offset), .out_valid(out_valid), .out_ready(out_ready),
      .out_wr_en(out_wr_en), .out_wr_idx(out_wr_idx), .out_wr_data(out_wr_data),
      .out_next_pc(out_next_pc), .out_taken(out_taken)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit ref_hit(input logic [3:0] c, input logic [31:0] f);
      bit ok = 1'b1;
      bit fl;
      for (int i = 0; i < 3; i++) begin
         fl = (i == 2) ? 1'b1 : f[29+i];
         if (c[i] && (fl != c[3])) ok = 1'b0;
      end
      return ok;
   endfunction

   function automatic string taken_tag(input logic [3:0] c);
      if (c[2:0] == 3'b000) return "R2";
      if (c[2:0] == 3'b100) return "R3";
      return "R1";
   endfunction

   // reference model and per-cycle comparison
   always @(posedge clk) begin
      if (!rst_n) begin
         m_v = 1'b0;
         acc_last = 1'b0;
      end else begin
         acc_last = in_valid && (!m_v || out_ready);
         if (!m_v || out_ready) begin
            m_v = in_valid;
            if (in_valid) begin
               m_taken = ref_hit(in_cond, in_flags);
               m_wen   = (in_dst > 4'd1);
               m_idx   = in_dst;
               m_cond  = in_cond;
               m_pc    = in_pc + 32'd4;
               if (m_taken) m_pc = m_pc + {{16{in_offset[15]}}, in_offset};
            end
         end
      end
      #2;
      if (rst_n) begin
         chk("R10 valid", 32'(out_valid), 32'(m_v));
         chk("R8 in_ready", 32'(in_ready), 32'(!m_v || out_ready));
         if (m_v) begin
            chk(taken_tag(m_cond), 32'(out_taken), 32'(m_taken));
            chk("R4 data", out_wr_data, m_taken ? 32'd1 : 32'd0);
            chk("R4 idx", 32'(out_wr_idx), 32'(m_idx));
            chk("R7 wen", 32'(out_wr_en), 32'(m_wen));
            chk(m_taken ? "R5 next_pc" : "R6 next_pc", out_next_pc, m_pc);
         end
      end
   end

   // output back-pressure
   initial begin
      int cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         out_ready = hold ? 1'b0 : ((cyc % 5) != 3);
      end
   end

   task automatic issue(input logic [3:0] c, input logic [31:0] f, input logic [3:0] d,
                        input logic [31:0] pc, input logic [15:0] ofs);
      @(negedge clk);
      in_valid = 1'b1; in_cond = c; in_flags = f; in_dst = d; in_pc = pc; in_offset = ofs;
      do begin
         @(posedge clk);
         #1;
      end while (!acc_last);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] pick_ofs(input int k);
      case (k % 6)
         0: return 16'h0000;
         1: return 16'h0010;
         2: return 16'h7FFF;
         3: return 16'h8000;
         4: return 16'hFFFF;
         default: return 16'hFFF8;
      endcase
   endfunction

   initial begin
      #(8 * 200000);
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset valid", 32'(out_valid), 32'd0);
      rst_n = 1'b1;
      // every condition against every flag pattern, bit 31 cleared in half of them
      for (int c = 0; c < 16; c++) begin
         for (int f = 0; f < 8; f++) begin
            issue(4'(c), {3'(f), 29'h0ABC_DEF1 ^ 29'(c * 7)}, 4'((c + f) % 16),
                  32'h0000_1000 + 32'(c * 256 + f * 8), pick_ofs(c * 8 + f));
         end
      end
      // wrap of the program counter, taken and fall-through
      issue(4'b1000, 32'h0, 4'd5, 32'hFFFF_FFFC, 16'h0000);
      issue(4'b1100, 32'h0, 4'd6, 32'hFFFF_FFF0, 16'h0020);
      issue(4'b0100, 32'hFFFF_FFFF, 4'd0, 32'hFFFF_FFFC, 16'h0040);
      issue(4'b1100, 32'h0, 4'd1, 32'h0000_0004, 16'hFFF8);
      // long stall on the output slot
      idle(4);
      hold = 1'b1;
      issue(4'b1010, 32'hC000_0000, 4'd9, 32'h0000_2000, 16'h8000);
      idle(8);
      hold = 1'b0;
      idle(6);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule